// File: doc/BRIEF.md
# PIO Timing to Clock Converter

This block turns the parallel ATA PIO timing of the two drives on one IDE channel into clock counts for a programmable timing controller. For each drive it takes a PIO mode number, or a flag saying the drive is absent. It also takes the bus frequency in MHz and a read-prefetch enable. A start strobe launches a run. Setup, active and cycle times in nanoseconds come from an internal mode table. Each time is converted to a whole number of clocks, always rounded up, and each count is clamped to the range its register field can hold.

A sequencer walks through the six conversions, three per drive. It hands each present drive's times to a bit-serial restoring divider. An absent drive gets the minimum counts at once. The results are packed into one cycle byte per drive and one shared byte. The shared byte carries the address setup of the slower drive, the prefetch enable and a fixed ready-wait code. A one-cycle done pulse marks the moment the three bytes update, and the bytes then hold until the next run completes.

Top module: `pio_clk_conv`

## Requirements
- R1: During and after synchronous reset, `busy` and `done` are low and `cycle_a`, `cycle_b` and `misc` are 0x00.
- R2: A start is accepted only in a cycle where `busy` is low, and this includes the cycle in which `done` is high. `busy` is high from the next cycle until `done` rises. A start while `busy` is high has no effect.
- R3: A time of t ns at f MHz converts to (t*f + 999)/1000 clocks, using integer division. The mode table gives setup/active/cycle times in ns: mode 0 is 70/165/600, mode 1 is 50/125/383, mode 2 is 30/100/240 and mode 3 is 30/80/180.
- R4: Recovery in ns is the cycle time minus the setup time minus the active time, and it is converted by the R3 rule.
- R5: Address clocks are clamped to 1..4, data clocks to 1..16 and recovery clocks to 2..17. This includes a bus frequency of 0, which gives the minimum of every field.
- R6: A mode value above 3 is treated as mode 3.
- R7: An absent drive takes 1 address clock, 1 data clock and 2 recovery clocks.
- R8: The shared address setup is the larger of the two drives' address clocks.
- R9: Each drive's cycle byte holds (data-1) in bits [7:4] and (recovery-2) in bits [3:0]. Drive A goes to `cycle_a` and drive B goes to `cycle_b`.
- R10: `misc` holds the prefetch enable in bit 6, (shared address-1) in bits [5:4] and (ready wait-2) in bits [2:1], with the ready wait fixed at 2. Bits 7, 3 and 0 are 0.
- R11: `done` is a one-cycle pulse that comes L cycles after the accepting edge. L = 1 + 3*(ca + cb), where a drive's cost c is 1 if it is absent and 20 if it is present, with an 8-bit frequency. This gives L = 121, 64 or 7. The output bytes change only when `done` is high.
- R12: Modes, absent flags, frequency and prefetch enable are sampled at the accepting edge. Changing them during a run does not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for one conversion run |
| mode_a | input | 3 | PIO mode of drive A |
| absent_a | input | 1 | Drive A is not present |
| mode_b | input | 3 | PIO mode of drive B |
| absent_b | input | 1 | Drive B is not present |
| bus_mhz | input | 8 | Bus frequency in MHz |
| prefetch_en | input | 1 | Read-prefetch enable placed in misc bit 6 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the output bytes update |
| cycle_a | output | 8 | Packed data/recovery byte for drive A |
| cycle_b | output | 8 | Packed data/recovery byte for drive B |
| misc | output | 8 | Shared address setup, ready wait and prefetch byte |

## Verification
Two events can fall in the same cycle: the completion of one run, with `done` high and the bytes updating, and the acceptance of the next start. The bench waits for its model to go idle and issues the next start right away. Most runs are therefore launched in the very cycle `done` is high. Each relaunched run is judged by its own latency, and by the bytes of the first run holding until the second run's pulse. A start issued in the last busy cycle is also sent and must be ignored.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int MAX_MODE  = 3;
    localparam int MAX_NS    = 600;
    localparam int NS_W      = $clog2(MAX_NS + 1);
    localparam int DIVISOR   = 1000;
    localparam int DV_W      = $clog2(DIVISOR + 1);
    localparam int CNT_W     = 5;

    typedef enum logic [1:0] {
        F_SETUP  = 2'd0,
        F_ACTIVE = 2'd1,
        F_RECOV  = 2'd2
    } field_e;

    typedef struct packed {
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] data;
        logic [CNT_W-1:0] recov;
    } clk_set_t;

    // Nanosecond figure for one field of one mode; recovery is derived.
    function automatic logic [NS_W-1:0] mode_ns(logic [1:0] m, field_e f);
        int s, a, c;
        case (m)
            2'd0:    begin s = 70; a = 165; c = 600; end
            2'd1:    begin s = 50; a = 125; c = 383; end
            2'd2:    begin s = 30; a = 100; c = 240; end
            default: begin s = 30; a = 80;  c = 180; end
        endcase
        case (f)
            F_SETUP:  return NS_W'(s);
            F_ACTIVE: return NS_W'(a);
            default:  return NS_W'(c - s - a);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] field_min(field_e f);
        return (f == F_RECOV) ? CNT_W'(2) : CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] field_max(field_e f);
        case (f)
            F_SETUP:  return CNT_W'(4);
            F_ACTIVE: return CNT_W'(16);
            default:  return CNT_W'(17);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_clk(int unsigned q, field_e f);
        if (q < 32'(field_min(f))) return field_min(f);
        if (q > 32'(field_max(f))) return field_max(f);
        return CNT_W'(q);
    endfunction

endpackage

// File: rtl/pio_div.sv
module pio_div #(
    parameter int N    = 18,
    parameter int DV_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [N-1:0]    dividend,
    input  logic [DV_W-1:0] divisor,
    output logic [N-1:0]    quot,
    output logic            fin
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]    q_r;
    logic [DV_W-1:0] r_r;
    logic [CW-1:0]   cnt;
    logic            run;

    logic [DV_W:0]   shifted;
    logic            take;
    logic [DV_W-1:0] r_next;

    always_comb begin
        shifted = {r_r, q_r[N-1]};
        take    = (shifted >= {1'b0, divisor});
        r_next  = take ? DV_W'(shifted - {1'b0, divisor}) : shifted[DV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
            r_r <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                q_r <= dividend;
                r_r <= '0;
                cnt <= CW'(N);
                run <= 1'b1;
            end else if (run) begin
                q_r <= {q_r[N-2:0], take};
                r_r <= r_next;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;

endmodule

// File: rtl/pio_pack.sv
module pio_pack
    import pio_timing_pkg::*;
(
    input  clk_set_t    set_a,
    input  clk_set_t    set_b,
    input  logic        pf,
    output logic [7:0]  cyc_a,
    output logic [7:0]  cyc_b,
    output logic [7:0]  misc_o
);
    localparam logic [1:0] RDY_CODE = 2'd0;  // ready wait of 2 clocks

    clk_set_t         sets [2];
    logic [7:0]       cyc [2];
    logic [CNT_W-1:0] ax, ax_m1;

    assign sets[0] = set_a;
    assign sets[1] = set_b;

    for (genvar d = 0; d < 2; d++) begin : g_drv
        logic [CNT_W-1:0] dm1, rm2;
        assign dm1    = sets[d].data - CNT_W'(1);
        assign rm2    = sets[d].recov - CNT_W'(2);
        assign cyc[d] = {dm1[3:0], rm2[3:0]};
    end

    assign ax     = (set_a.addr > set_b.addr) ? set_a.addr : set_b.addr;
    assign ax_m1  = ax - CNT_W'(1);
    assign cyc_a  = cyc[0];
    assign cyc_b  = cyc[1];
    assign misc_o = {1'b0, pf, ax_m1[1:0], 1'b0, RDY_CODE, 1'b0};

endmodule

// File: rtl/pio_clk_conv.sv
module pio_clk_conv
    import pio_timing_pkg::*;
#(
    parameter int FREQ_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode_a,
    input  logic              absent_a,
    input  logic [2:0]        mode_b,
    input  logic              absent_b,
    input  logic [FREQ_W-1:0] bus_mhz,
    input  logic              prefetch_en,
    output logic              busy,
    output logic              done,
    output logic [7:0]        cycle_a,
    output logic [7:0]        cycle_b,
    output logic [7:0]        misc
);
    localparam int DIV_W  = $clog2(MAX_NS * ((1 << FREQ_W) - 1) + DIVISOR);
    localparam int LAST_I = 5;

    typedef enum logic [1:0] {S_IDLE, S_PREP, S_WAIT, S_FIN} state_e;

    state_e            state;
    logic [2:0]        idx;
    logic [1:0]        m_r [2];
    logic [1:0]        ab_r;
    logic [FREQ_W-1:0] f_r;
    logic              pf_r;
    clk_set_t          res [2];

    logic              drv;
    field_e            fld;
    logic [DIV_W-1:0]  dvd;
    logic [DIV_W-1:0]  quot;
    logic              div_go, div_fin;
    logic [CNT_W-1:0]  min_v, clamped;
    logic [7:0]        pk_a, pk_b, pk_m;

    function automatic logic [1:0] sat_mode(logic [2:0] m);
        return (m > 3'(MAX_MODE)) ? 2'(MAX_MODE) : m[1:0];
    endfunction

    always_comb begin
        drv     = (idx >= 3'd3);
        fld     = field_e'(drv ? 2'(idx - 3'd3) : idx[1:0]);
        dvd     = DIV_W'(mode_ns(m_r[drv], fld)) * DIV_W'(f_r) + DIV_W'(DIVISOR - 1);
        div_go  = (state == S_PREP) && !ab_r[drv];
        min_v   = field_min(fld);
        clamped = clamp_clk(32'(quot), fld);
    end

    pio_div #(.N(DIV_W), .DV_W(DV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (dvd),
        .divisor  (DV_W'(DIVISOR)),
        .quot     (quot),
        .fin      (div_fin)
    );

    pio_pack u_pack (
        .set_a  (res[0]),
        .set_b  (res[1]),
        .pf     (pf_r),
        .cyc_a  (pk_a),
        .cyc_b  (pk_b),
        .misc_o (pk_m)
    );

    function automatic clk_set_t put(clk_set_t s, field_e f, logic [CNT_W-1:0] v);
        clk_set_t o = s;
        case (f)
            F_SETUP:  o.addr  = v;
            F_ACTIVE: o.data  = v;
            default:  o.recov = v;
        endcase
        return o;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            idx     <= '0;
            m_r[0]  <= '0;
            m_r[1]  <= '0;
            ab_r    <= '0;
            f_r     <= '0;
            pf_r    <= 1'b0;
            res[0]  <= '0;
            res[1]  <= '0;
            done    <= 1'b0;
            cycle_a <= '0;
            cycle_b <= '0;
            misc    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    m_r[0] <= sat_mode(mode_a);
                    m_r[1] <= sat_mode(mode_b);
                    ab_r   <= {absent_b, absent_a};
                    f_r    <= bus_mhz;
                    pf_r   <= prefetch_en;
                    idx    <= '0;
                    state  <= S_PREP;
                end
                S_PREP: begin
                    if (ab_r[drv]) begin
                        res[drv] <= put(res[drv], fld, min_v);
                        idx      <= idx + 1'b1;
                        state    <= (idx == 3'(LAST_I)) ? S_FIN : S_PREP;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: if (div_fin) begin
                    res[drv] <= put(res[drv], fld, clamped);
                    idx      <= idx + 1'b1;
                    state    <= (idx == 3'(LAST_I)) ? S_FIN : S_PREP;
                end
                default: begin
                    cycle_a <= pk_a;
                    cycle_b <= pk_b;
                    misc    <= pk_m;
                    done    <= 1'b1;
                    state   <= S_IDLE;
                end
            endcase
        end
    end

    assign busy = (state != S_IDLE);

endmodule

// File: rtl/pio_clk_conv_chk.sv
module pio_clk_conv_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] cycle_a,
    input logic [7:0] cycle_b,
    input logic [7:0] misc
);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_hold_bytes_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cycle_a) && $stable(cycle_b) && $stable(misc)));

    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_rise_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind pio_clk_conv pio_clk_conv_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .cycle_a (cycle_a),
    .cycle_b (cycle_b),
    .misc    (misc)
);

// File: tb/pio_clk_conv_test.sv
module pio_clk_conv_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] mode_a = '0, mode_b = '0;
    logic       absent_a = 1'b0, absent_b = 1'b0;
    logic [7:0] bus_mhz = '0;
    logic       prefetch_en = 1'b0;
    logic       busy, done;
    logic [7:0] cycle_a, cycle_b, misc;

    always #5 clk = ~clk;

    pio_clk_conv uut (
        .clk(clk), .rst(rst), .start(start),
        .mode_a(mode_a), .absent_a(absent_a),
        .mode_b(mode_b), .absent_b(absent_b),
        .bus_mhz(bus_mhz), .prefetch_en(prefetch_en),
        .busy(busy), .done(done),
        .cycle_a(cycle_a), .cycle_b(cycle_b), .misc(misc)
    );

    int checks = 0, errors = 0, cycles = 0;
    bit cmp_en = 0;
    string tag = "R1 reset";

    // Reference model state
    int cnt = 0;
    bit e_done = 0;
    int e_ca = 0, e_cb = 0, e_m = 0;
    int p_ca = 0, p_cb = 0, p_m = 0;

    int t_set[4] = '{70, 50, 30, 30};
    int t_act[4] = '{165, 125, 100, 80};
    int t_cyc[4] = '{600, 383, 240, 180};

    function automatic int to_clk(int ns, int f);
        return (ns * f + 999) / 1000;
    endfunction

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic drive_clocks(input int m, input bit ab, input int f,
                                output int a, output int d, output int r);
        int mm;
        if (ab) begin a = 1; d = 1; r = 2; end
        else begin
            mm = (m > 3) ? 3 : m;
            a = lim(to_clk(t_set[mm], f), 1, 4);
            d = lim(to_clk(t_act[mm], f), 1, 16);
            r = lim(to_clk(t_cyc[mm] - t_set[mm] - t_act[mm], f), 2, 17);
        end
    endtask

    always @(posedge clk) begin
        int aa, da, ra, ab, db, rb;
        if (rst) begin
            cnt = 0; e_done = 0; e_ca = 0; e_cb = 0; e_m = 0;
        end else begin
            e_done = 0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    e_done = 1; e_ca = p_ca; e_cb = p_cb; e_m = p_m;
                end
            end else if (start) begin
                drive_clocks(mode_a, absent_a, bus_mhz, aa, da, ra);
                drive_clocks(mode_b, absent_b, bus_mhz, ab, db, rb);
                p_ca = ((da - 1) << 4) | (ra - 2);
                p_cb = ((db - 1) << 4) | (rb - 2);
                p_m  = (prefetch_en << 6) | ((((aa > ab) ? aa : ab) - 1) << 4);
                cnt  = 1 + 3 * ((absent_a ? 1 : 20) + (absent_b ? 1 : 20));
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (done !== e_done || busy !== (cnt > 0)) begin
                errors++;
                $display("FAIL %s R11/R2 done/busy got %b/%b exp %b/%b",
                         tag, done, busy, e_done, cnt > 0);
            end
            if (cycle_a !== 8'(e_ca) || cycle_b !== 8'(e_cb)) begin
                errors++;
                $display("FAIL %s R9 cycle bytes got %h/%h exp %h/%h",
                         tag, cycle_a, cycle_b, 8'(e_ca), 8'(e_cb));
            end
            if (misc !== 8'(e_m)) begin
                errors++;
                $display("FAIL %s R10 misc got %h exp %h", tag, misc, 8'(e_m));
            end
        end
    end

    task automatic issue(input string t, input int ma, input bit aa,
                         input int mb, input bit ab, input int f, input bit pf);
        tag = t;
        mode_a = 3'(ma); absent_a = aa; mode_b = 3'(mb); absent_b = ab;
        bus_mhz = 8'(f); prefetch_en = pf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (cnt != 0) @(negedge clk);
    endtask

    initial begin
        repeat (1) @(negedge clk);
        cmp_en = 1;                               // R1 reset values
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        issue("R3 modes 3/3 at 33", 3, 0, 3, 0, 33, 1); wait_idle();
        issue("R3 R4 modes 0/2 at 50", 0, 0, 2, 0, 50, 0); wait_idle();
        issue("R4 R8 modes 1/3 at 100", 1, 0, 3, 0, 100, 1); wait_idle();
        issue("R6 modes 7/5 at 66", 7, 0, 5, 0, 66, 0); wait_idle();
        issue("R7 drive B absent", 1, 0, 0, 1, 40, 1); wait_idle();
        issue("R7 R8 drive A absent", 0, 1, 0, 0, 120, 0); wait_idle();
        issue("R7 both absent", 2, 1, 3, 1, 90, 1); wait_idle();
        issue("R5 zero frequency", 0, 0, 1, 0, 0, 0); wait_idle();
        issue("R5 top frequency", 0, 0, 0, 0, 255, 1); wait_idle();
        repeat (4) @(negedge clk);

        // R12: inputs changed mid-run; R2: starts while busy are ignored
        issue("R12 R2 busy start", 2, 0, 1, 0, 25, 1);
        repeat (10) @(negedge clk);
        mode_a = 3'd0; bus_mhz = 8'd200; absent_b = 1'b1; prefetch_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cnt > 1) @(negedge clk);
        start = 1'b1;                              // last busy cycle
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R2 R11: start coinciding with done, back to back
        issue("R2 R11 back-to-back", 3, 0, 0, 0, 66, 1); wait_idle();
        issue("R2 R11 back-to-back", 1, 0, 2, 1, 33, 0); wait_idle();
        repeat (5) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule